// File: doc/BRIEF.md
# Two-Wire Command-Register Slave

This block is a synchronous slave for a two-wire serial bus. It runs on a fast system clock and oversamples the bus clock and data lines. It pulls the data line low through an open-drain enable. A host uses it to read and write an internal register set. Every register is selected by an 8-bit command code that the host writes at the start of each transaction.

After a start condition the slave compares the 7-bit address byte against its own address. The upper five bits of that address are fixed by a parameter, and the two low bits come from strap inputs. A write transaction carries a command code, which becomes the register pointer, followed by zero or more data bytes. A write of only a command, ended by a stop, produces a one-cycle fault-clear pulse. A read first writes the command, then issues a repeated start and the read address, and the slave shifts out bytes MSB first. Multi-byte values travel low byte first. Commands at or above a parameterised threshold are block commands: their first data byte is a byte count and is not stored.

The register side is a plain port. The slave presents a pointer and a byte index, pulses a write strobe with the data byte, and reads the byte that the register file returns for the current pointer and index.

Top module: `smb_regslave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper five bits are 11000 and its two low bits equal `strap_a`. Bit 0 of that byte is the direction: 0 means write, 1 means read. After any other address the slave never pulls SDA and makes no register write until the next start or stop.
- R2: In a write byte transaction (address/write, command, one data byte, stop), every byte is acknowledged. Exactly one `reg_we` pulse follows, with `reg_ptr` equal to the command, `reg_idx` equal to 0 and `reg_wdata` equal to the data byte.
- R3: For a command below the block threshold (0xE0 by default), data bytes are stored low byte first at indices 0 and 1. A third data byte is not acknowledged and is not written.
- R4: A write transaction ended by a stop right after the acknowledged command gives exactly one `fault_clr` pulse, one cycle wide, and no register write. A transaction that carries data, or that continues with a repeated start, gives no pulse.
- R5: For a command of 0xE0 or above, the first data byte is a count N. It is acknowledged and not written. The next N bytes are acknowledged and written at indices 0 to N-1. Any further byte is not acknowledged and not written.
- R6: After address/write, command, repeated start and address/read, the slave acknowledges. It then shifts out `reg_rdata` for `reg_ptr` equal to the command and `reg_idx` equal to 0, MSB first.
- R7: When the master acknowledges a read byte, the next byte comes from `reg_idx` plus one. When the master does not acknowledge, the slave keeps SDA released until the next start or stop.
- R8: A read address is not acknowledged, and SDA is not pulled, unless a command was written earlier in the same transaction. A pointer left over from an earlier transaction is not reused.
- R9: After reset `sda_pull`, `reg_we` and `fault_clr` are low. `sda_pull` changes only while SCL is low.
- R10: `reg_we` and `fault_clr` are single-cycle pulses and never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| strap_a | input | STRAP_W | Strapped low bits of the slave address |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_ptr | output | 8 | Command code currently selected |
| reg_idx | output | IDX_W | Byte index within the selected register |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write when `reg_we` is high |
| reg_rdata | input | 8 | Register-file byte for `reg_ptr`/`reg_idx` |
| fault_clr | output | 1 | One-cycle pulse for a command-only write |

## Verification
The bench tries all sixteen pairings of strap value and address low bits, and it flips each fixed address bit in turn. A faulty matcher would answer a neighbour's address, or would keep listening and write data after a mismatch. Block writes are swept over counts 0 to 3, each with one byte too many, and the command just below the threshold is tested for contrast. An off-by-one in the count check would acknowledge or store the surplus byte, and a wrong threshold would store the count as data. Reads cover the acknowledged and the not-acknowledged paths, and a slave that failed to release would corrupt the extra byte clocked after the not-acknowledge. Address/read without a fresh command, and the difference between a command-only write and a read set-up, target pointer reuse and false fault-clear pulses.

// File: rtl/smb_pkg.sv
package smb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WDATA,
      ST_TXA,
      ST_TX,
      ST_IGNORE
   } smb_state_e;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic sda;
      logic start;
      logic stop;
   } smb_line_t;

endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   output smb_pkg::smb_line_t line
);

   logic [SYNC_STAGES-1:0] scl_pipe;
   logic [SYNC_STAGES-1:0] sda_pipe;
   logic                   scl_d;
   logic                   sda_d;
   logic                   scl_s;
   logic                   sda_s;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[0] <= 1'b1;
               sda_pipe[0] <= 1'b1;
            end else begin
               scl_pipe[0] <= scl_in;
               sda_pipe[0] <= sda_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[g] <= 1'b1;
               sda_pipe[g] <= 1'b1;
            end else begin
               scl_pipe[g] <= scl_pipe[g-1];
               sda_pipe[g] <= sda_pipe[g-1];
            end
         end
      end
   end

   assign scl_s = scl_pipe[SYNC_STAGES-1];
   assign sda_s = sda_pipe[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_comb begin
      line.scl_rise = scl_s & ~scl_d;
      line.scl_fall = ~scl_s & scl_d;
      line.sda      = sda_s;
      line.start    = scl_s & scl_d & sda_d & ~sda_s;
      line.stop     = scl_s & scl_d & ~sda_d & sda_s;
   end

endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match #(
   parameter int         STRAP_W   = 2,
   parameter logic [6:0] BASE_ADDR = 7'h60
) (
   input  logic [6:0]         addr7,
   input  logic [STRAP_W-1:0] strap,
   output logic               hit
);

   if (STRAP_W == 0) begin : g_fixed_only
      assign hit = (addr7 == BASE_ADDR);
   end else begin : g_strapped
      localparam int FIXED_W = 7 - STRAP_W;
      logic [FIXED_W-1:0] upper_ref;
      assign upper_ref = BASE_ADDR[6:STRAP_W];
      assign hit = (addr7[6:STRAP_W] == upper_ref) &&
                   (addr7[STRAP_W-1:0] == strap);
   end

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm #(
   parameter int         IDX_W       = 4,
   parameter int         WORD_BYTES  = 2,
   parameter logic [7:0] BLK_CMD_MIN = 8'hE0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  smb_pkg::smb_line_t line,
   input  logic               addr_hit,
   output logic [6:0]         addr7,
   output logic               sda_pull,
   output logic [7:0]         reg_ptr,
   output logic [IDX_W-1:0]   reg_idx,
   output logic               reg_we,
   output logic [7:0]         reg_wdata,
   input  logic [7:0]         reg_rdata,
   output logic               fault_clr
);
   import smb_pkg::*;

   localparam logic [8:0] IDX_LIM  = 9'(2 ** IDX_W);
   localparam logic [8:0] WORD_LIM = 9'(WORD_BYTES);

   smb_state_e state;
   logic [3:0] bitcnt;
   logic [7:0] shreg;
   logic [7:0] txreg;
   logic [7:0] wcnt;
   logic [7:0] blk_n;
   logic       in_ack;
   logic       ptr_ok;
   logic       is_blk;
   logic       have_n;
   logic       got_data;
   logic       blk_accept;
   logic       word_accept;

   assign addr7       = shreg[7:1];
   assign reg_idx     = wcnt[IDX_W-1:0];
   assign blk_accept  = (wcnt < blk_n) && ({1'b0, wcnt} < IDX_LIM);
   assign word_accept = ({1'b0, wcnt} < WORD_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         txreg     <= '0;
         wcnt      <= '0;
         blk_n     <= '0;
         in_ack    <= 1'b0;
         ptr_ok    <= 1'b0;
         is_blk    <= 1'b0;
         have_n    <= 1'b0;
         got_data  <= 1'b0;
         sda_pull  <= 1'b0;
         reg_ptr   <= '0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
         fault_clr <= 1'b0;
      end else begin
         reg_we    <= 1'b0;
         fault_clr <= 1'b0;
         if (reg_we) wcnt <= wcnt + 8'd1;

         if (line.start) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
         end else if (line.stop) begin
            fault_clr <= (state == ST_WDATA) && !got_data;
            state     <= ST_IDLE;
            ptr_ok    <= 1'b0;
            in_ack    <= 1'b0;
            sda_pull  <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (line.scl_rise && bitcnt < 4'd8) begin
                     shreg  <= {shreg[6:0], line.sda};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (line.scl_fall && in_ack) begin
                     in_ack   <= 1'b0;
                     sda_pull <= 1'b0;
                     bitcnt   <= '0;
                  end else if (line.scl_fall && bitcnt == 4'd8) begin
                     in_ack <= 1'b1;
                     if (state == ST_ADDR) begin
                        if (!addr_hit) begin
                           state    <= ST_IGNORE;
                           sda_pull <= 1'b0;
                        end else if (!shreg[0]) begin
                           state    <= ST_CMD;
                           ptr_ok   <= 1'b0;
                           sda_pull <= 1'b1;
                        end else if (ptr_ok) begin
                           state    <= ST_TXA;
                           wcnt     <= '0;
                           sda_pull <= 1'b1;
                        end else begin
                           state    <= ST_IGNORE;
                           sda_pull <= 1'b0;
                        end
                     end else if (state == ST_CMD) begin
                        reg_ptr  <= shreg;
                        ptr_ok   <= 1'b1;
                        is_blk   <= (shreg >= BLK_CMD_MIN);
                        have_n   <= 1'b0;
                        got_data <= 1'b0;
                        wcnt     <= '0;
                        sda_pull <= 1'b1;
                        state    <= ST_WDATA;
                     end else begin
                        got_data <= 1'b1;
                        if (is_blk && !have_n) begin
                           blk_n    <= shreg;
                           have_n   <= 1'b1;
                           sda_pull <= 1'b1;
                        end else if (is_blk ? blk_accept : word_accept) begin
                           reg_we    <= 1'b1;
                           reg_wdata <= shreg;
                           sda_pull  <= 1'b1;
                        end else begin
                           sda_pull <= 1'b0;
                        end
                     end
                  end
               end
               ST_TXA: begin
                  if (line.scl_fall && in_ack) begin
                     in_ack   <= 1'b0;
                     state    <= ST_TX;
                     txreg    <= reg_rdata;
                     sda_pull <= ~reg_rdata[7];
                     bitcnt   <= '0;
                  end
               end
               ST_TX: begin
                  if (line.scl_rise) begin
                     if (in_ack) begin
                        if (line.sda) state <= ST_IGNORE;
                        else          wcnt  <= wcnt + 8'd1;
                     end else begin
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end else if (line.scl_fall) begin
                     if (in_ack) begin
                        in_ack   <= 1'b0;
                        txreg    <= reg_rdata;
                        sda_pull <= ~reg_rdata[7];
                        bitcnt   <= '0;
                     end else if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b0;
                        in_ack   <= 1'b1;
                     end else begin
                        sda_pull <= ~txreg[6];
                        txreg    <= {txreg[6:0], 1'b0};
                     end
                  end
               end
               default: begin
                  sda_pull <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave #(
   parameter int         STRAP_W     = 2,
   parameter logic [6:0] BASE_ADDR   = 7'h60,
   parameter int         SYNC_STAGES = 2,
   parameter int         IDX_W       = 4,
   parameter int         WORD_BYTES  = 2,
   parameter logic [7:0] BLK_CMD_MIN = 8'hE0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic [STRAP_W-1:0] strap_a,
   output logic               sda_pull,
   output logic [7:0]         reg_ptr,
   output logic [IDX_W-1:0]   reg_idx,
   output logic               reg_we,
   output logic [7:0]         reg_wdata,
   input  logic [7:0]         reg_rdata,
   output logic               fault_clr
);

   if (STRAP_W < 1 || STRAP_W > 3) begin : g_bad_strap
      $error("STRAP_W must lie in 1..3");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must lie in 1..8");
   end
   if (WORD_BYTES < 1 || WORD_BYTES > (2 ** IDX_W)) begin : g_bad_word
      $error("WORD_BYTES must fit the index range");
   end

   smb_pkg::smb_line_t line;
   logic [6:0]         addr7;
   logic               addr_hit;

   smb_line_cond #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_in (scl_in),
      .sda_in (sda_in),
      .line   (line)
   );

   smb_addr_match #(
      .STRAP_W   (STRAP_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_match (
      .addr7 (addr7),
      .strap (strap_a),
      .hit   (addr_hit)
   );

   smb_proto_fsm #(
      .IDX_W       (IDX_W),
      .WORD_BYTES  (WORD_BYTES),
      .BLK_CMD_MIN (BLK_CMD_MIN)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (line),
      .addr_hit  (addr_hit),
      .addr7     (addr7),
      .sda_pull  (sda_pull),
      .reg_ptr   (reg_ptr),
      .reg_idx   (reg_idx),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .fault_clr (fault_clr)
   );

endmodule

module smb_regslave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_in,
   input logic sda_pull,
   input logic reg_we,
   input logic fault_clr
);

   assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !scl_in);

   assert_we_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   assert_fault_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr |=> !fault_clr);

   assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && fault_clr));

   assert_fault_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr |-> (scl_in && !sda_pull));

endmodule

bind smb_regslave smb_regslave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_in    (scl_in),
   .sda_pull  (sda_pull),
   .reg_we    (reg_we),
   .fault_clr (fault_clr)
);

// File: tb/smb_regslave_bench.sv
module smb_regslave_bench;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 5;
   localparam int WD_CYCLES  = 180000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [1:0] strap = 2'd0;
   logic       sda_pull;
   logic [7:0] reg_ptr;
   logic [3:0] reg_idx;
   logic       reg_we;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       fault_clr;
   logic       sda_line;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign sda_line = m_sda & ~sda_pull;

   function automatic logic [7:0] exp_rd(input logic [7:0] p, input logic [3:0] i);
      return p * 8'd7 + {4'd0, i} * 8'd29 + 8'h5A;
   endfunction

   assign reg_rdata = exp_rd(reg_ptr, reg_idx);

   smb_regslave u_smb_regslave (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (m_scl),
      .sda_in    (sda_line),
      .strap_a   (strap),
      .sda_pull  (sda_pull),
      .reg_ptr   (reg_ptr),
      .reg_idx   (reg_idx),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .fault_clr (fault_clr)
   );

   int         n_cmp = 0;
   int         n_bad = 0;
   int         n_wr = 0;
   int         n_fc = 0;
   int         n_pull = 0;
   logic [7:0] lg_ptr [64];
   logic [3:0] lg_idx [64];
   logic [7:0] lg_dat [64];
   logic [7:0] txd [16];

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we && n_wr < 64) begin
            lg_ptr[n_wr] = reg_ptr;
            lg_idx[n_wr] = reg_idx;
            lg_dat[n_wr] = reg_wdata;
            n_wr++;
         end
         if (fault_clr) n_fc++;
         if (sda_pull) n_pull++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_xfer(input logic drv, output logic seen);
      m_sda = drv;
      qw();
      m_scl = 1'b1;
      qw();
      seen = sda_line;
      qw();
      m_scl = 1'b0;
      qw();
   endtask

   task automatic bus_start();
      m_sda = 1'b1;
      qw();
      m_scl = 1'b1;
      qw();
      m_sda = 1'b0;
      qw();
      m_scl = 1'b0;
      qw();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0;
      qw();
      m_scl = 1'b1;
      qw();
      m_sda = 1'b1;
      qw();
   endtask

   task automatic byte_out(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
      bit_xfer(1'b1, s);
      ack = ~s;
      m_sda = 1'b1;
   endtask

   task automatic byte_in(input logic mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, s);
         d[i] = s;
      end
      bit_xfer(~mack, s);
      m_sda = 1'b1;
   endtask

   // Address/W, command, nd bytes from txd, stop. Bit k of acks = ack of byte k.
   task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input int nd,
                         output int acks);
      logic ak;
      acks = 0;
      bus_start();
      byte_out({a, 1'b0}, ak);
      acks |= int'(ak);
      byte_out(cmd, ak);
      acks |= int'(ak) << 1;
      for (int k = 0; k < nd; k++) begin
         byte_out(txd[k], ak);
         acks |= int'(ak) << (k + 2);
      end
      bus_stop();
   endtask

   task automatic rd_txn(input logic [6:0] a, input logic [7:0] cmd, input int nb,
                         output int acks, output logic [7:0] r0, output logic [7:0] r1);
      logic ak;
      acks = 0;
      r1 = 8'h00;
      bus_start();
      byte_out({a, 1'b0}, ak);
      acks |= int'(ak);
      byte_out(cmd, ak);
      acks |= int'(ak) << 1;
      bus_start();
      byte_out({a, 1'b1}, ak);
      acks |= int'(ak) << 2;
      byte_in(nb > 1, r0);
      if (nb > 1) byte_in(1'b0, r1);
      bus_stop();
   endtask

   logic [6:0] own;
   assign own = {5'b11000, strap};

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int         acks;
      int         w0;
      int         f0;
      int         p0;
      logic       ak;
      logic [7:0] r0;
      logic [7:0] r1;
      logic [7:0] cmds [4];

      repeat (5) @(negedge clk);
      chk("R9 reset sda_pull", int'(sda_pull), 0);
      chk("R9 reset reg_we", int'(reg_we), 0);
      chk("R9 reset fault_clr", int'(fault_clr), 0);
      rst_n = 1'b1;
      qw();

      // R1: sweep every strap value against every address low pair
      f0 = n_fc;
      for (int s = 0; s < 4; s++) begin
         strap = 2'(s);
         for (int lo = 0; lo < 4; lo++) begin
            bus_start();
            byte_out({5'b11000, 2'(lo), 1'b0}, ak);
            bus_stop();
            chk($sformatf("R1 ack strap=%0d lo=%0d", s, lo), int'(ak), int'(lo == s));
         end
      end
      chk("R4 no pulse from address-only", n_fc, f0);

      // R1: each fixed bit flipped -> silent, no writes
      strap = 2'd2;
      for (int b = 0; b < 5; b++) begin
         w0 = n_wr;
         p0 = n_pull;
         txd[0] = 8'h3C;
         txd[1] = 8'hC3;
         wr_txn({5'b11000 ^ 5'(1 << b), strap}, 8'h10, 2, acks);
         chk($sformatf("R1 mismatch bit%0d acks", b + 2), acks, 0);
         chk($sformatf("R1 mismatch bit%0d pull", b + 2), n_pull, p0);
         chk($sformatf("R1 mismatch bit%0d writes", b + 2), n_wr, w0);
      end

      // R2: write byte over several commands
      cmds[0] = 8'h00; cmds[1] = 8'h21; cmds[2] = 8'h7F; cmds[3] = 8'hDF;
      for (int c = 0; c < 4; c++) begin
         w0 = n_wr;
         f0 = n_fc;
         txd[0] = cmds[c] ^ 8'hA5;
         wr_txn(own, cmds[c], 1, acks);
         chk("R2 acks", acks, 7);
         chk("R2 write count", n_wr - w0, 1);
         chk("R2 ptr", int'(lg_ptr[w0]), int'(cmds[c]));
         chk("R2 idx", int'(lg_idx[w0]), 0);
         chk("R2 data", int'(lg_dat[w0]), int'(cmds[c] ^ 8'hA5));
         chk("R4 no pulse on write byte", n_fc, f0);
      end

      // R3: word low then high, third byte refused
      w0 = n_wr;
      txd[0] = 8'h12; txd[1] = 8'h34; txd[2] = 8'h56;
      wr_txn(own, 8'h40, 3, acks);
      chk("R3 acks", acks, 15);
      chk("R3 write count", n_wr - w0, 2);
      chk("R3 low idx", int'(lg_idx[w0]), 0);
      chk("R3 low data", int'(lg_dat[w0]), 8'h12);
      chk("R3 high idx", int'(lg_idx[w0 + 1]), 1);
      chk("R3 high data", int'(lg_dat[w0 + 1]), 8'h34);

      // R5: block writes, N = 0..3, one surplus byte each
      for (int n = 0; n < 4; n++) begin
         w0 = n_wr;
         txd[0] = 8'(n);
         for (int k = 0; k <= n; k++) txd[k + 1] = 8'(8'h80 + 16 * n + k);
         wr_txn(own, 8'(8'hE0 + n), n + 2, acks);
         chk($sformatf("R5 acks N=%0d", n), acks, (1 << (n + 3)) - 1);
         chk($sformatf("R5 writes N=%0d", n), n_wr - w0, n);
         for (int k = 0; k < n; k++) begin
            chk("R5 idx", int'(lg_idx[w0 + k]), k);
            chk("R5 data", int'(lg_dat[w0 + k]), 8'h80 + 16 * n + k);
            chk("R5 ptr", int'(lg_ptr[w0 + k]), 8'hE0 + n);
         end
      end

      // R4: command-only write
      w0 = n_wr;
      f0 = n_fc;
      wr_txn(own, 8'h03, 0, acks);
      chk("R4 send byte acks", acks, 3);
      chk("R4 one pulse", n_fc - f0, 1);
      chk("R4 no write", n_wr, w0);

      // R6: read byte over several commands
      cmds[0] = 8'h05; cmds[1] = 8'h88; cmds[2] = 8'hE1; cmds[3] = 8'hFF;
      for (int c = 0; c < 4; c++) begin
         f0 = n_fc;
         rd_txn(own, cmds[c], 1, acks, r0, r1);
         chk("R6 acks", acks, 7);
         chk("R6 data", int'(r0), int'(exp_rd(cmds[c], 4'd0)));
         chk("R4 no pulse on read set-up", n_fc, f0);
      end

      // R7: read word, then confirm release after the not-acknowledge
      bus_start();
      byte_out({own, 1'b0}, ak);
      byte_out(8'h31, ak);
      bus_start();
      byte_out({own, 1'b1}, ak);
      chk("R7 read addr ack", int'(ak), 1);
      byte_in(1'b1, r0);
      byte_in(1'b0, r1);
      chk("R7 low byte", int'(r0), int'(exp_rd(8'h31, 4'd0)));
      chk("R7 high byte", int'(r1), int'(exp_rd(8'h31, 4'd1)));
      p0 = n_pull;
      byte_in(1'b0, r0);
      chk("R7 released data", int'(r0), 8'hFF);
      chk("R7 released pull", n_pull, p0);
      bus_stop();

      // R8: read without a fresh command
      p0 = n_pull;
      bus_start();
      byte_out({own, 1'b1}, ak);
      bus_stop();
      chk("R8 cold read nack", int'(ak), 0);
      chk("R8 cold read pull", n_pull, p0);
      f0 = n_fc;
      wr_txn(own, 8'h22, 0, acks);
      chk("R4 pulse before stale read", n_fc - f0, 1);
      p0 = n_pull;
      bus_start();
      byte_out({own, 1'b1}, ak);
      byte_in(1'b0, r0);
      bus_stop();
      chk("R8 stale pointer nack", int'(ak), 0);
      chk("R8 stale pointer data", int'(r0), 8'hFF);
      chk("R8 stale pointer pull", n_pull, p0);

      qw();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule